// File: doc/BRIEF.md
# Flash Host-Mode Command Controller

This block is the command front end that lets an external programmer reach on-chip flash while the processor core is held stopped. The block treats the chip as being in host mode while the device reset pin is high and the program-store-enable input is low. In host mode it decodes a 4-bit command from control pins. It answers signature and lock-bit reads without delay, and it forwards main-code verify reads to the array read port. Erase and program requests go to a separate self-timed sequencer over a valid/ready request channel.

Two protections shape the write path. No erase or program command is acted on until a signature read has armed the interface during the current host-mode session. Three lock bits refuse command classes selectively. A falling edge on the active-low program strobe launches a write command. The strobe is resynchronised, and command, address and data are captured at the detected edge. Refused commands raise a sticky observation flag and leave the array port and the busy/timeout outputs untouched.

Request back-pressure works as follows. Once `arr_valid` rises, it stays high with `arr_op`, `arr_addr` and `arr_data` held constant until a cycle in which `arr_ready` is high. The operation is then running until `arr_done` pulses, with `arr_fail` giving the outcome. No new write command is accepted while a request is pending or running.

Top module: `flash_host_ctrl`

## Requirements
- R1: Host mode holds only while `rst_pin`=1 and `psen_n`=0. Outside host mode `dout_en` is 0, and a program-strobe edge issues no request and leaves `rejected` unchanged.
- R2: Command 0h is a signature read. Address 0030h returns D5h, 0031h returns the size code (04h, 08h or 10h for SIZE_KB 16, 32 or 64), and 0032h returns FFh, each with `dout_en`=1. Any other address gives `dout_en`=0 and `dout`=00h.
- R3: Write-class commands (1h, 2h, 4h, Eh, Fh, 3h, 5h) that arrive before a signature read at 0030h–0032h in the current host-mode session issue no request and set `rejected`. Arming is lost at power reset (`rst_n`) and on leaving host mode.
- R4: A falling `prog_n` edge with an accepted erase or program command raises `arr_valid`. The op field encodes chip erase as 00, block-1 erase as 01, block-2 erase as 10 and byte program as 11. Address and data are those present at the edge, and all fields hold until `arr_ready`.
- R5: `busy` rises with a launch and falls after the handshake once `arr_done` pulses. A write command arriving while `busy` is high is refused with no new request.
- R6: On `arr_done`, `timeout` takes `arr_fail`, and the next launch clears it. Refused commands and lock-bit programming leave `busy` and `timeout` unchanged.
- R7: Commands Fh, 3h and 5h set lock bit 1, 2 and 3 without an array request. Command 9h returns `dout`={0000, LB3, LB2, LB1, 0} with `dout_en`=1.
- R8: Block-1 erase, block-2 erase and byte program are refused when lock bit 2 or lock bit 3 is set.
- R9: Chip erase is accepted whatever the lock bits, and it clears all three lock bits.
- R10: Command Ch with no lock bit set drives `arr_rd_en`=1, `dout`=`arr_rdata` and `dout_en`=1. With any lock bit set, `dout_en`, `arr_rd_en` and `dout` are all 0.
- R11: Block-2 erase (command 4h) is accepted only when SIZE_KB is 64. In the other sizes it is refused.
- R12: `rejected` is 0 after power reset, and once set it stays set until the next power reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Power-on reset, active low |
| rst_pin | input | 1 | Device reset pin, high for host mode |
| psen_n | input | 1 | Program-store-enable input, low for host mode |
| prog_n | input | 1 | Program strobe, falling edge launches writes |
| cmd | input | 4 | Command code |
| addr | input | ADDR_W | Flash address bus |
| din | input | DATA_W | Write data bus |
| dout | output | DATA_W | Read data |
| dout_en | output | 1 | Read data valid |
| busy | output | 1 | Write operation pending or running |
| timeout | output | 1 | Last operation failed |
| rejected | output | 1 | Sticky refused-command flag |
| arr_valid | output | 1 | Array request valid |
| arr_ready | input | 1 | Array request accepted |
| arr_op | output | 2 | Array operation code |
| arr_addr | output | ADDR_W | Array request address |
| arr_data | output | DATA_W | Array request data |
| arr_done | input | 1 | Array operation finished |
| arr_fail | input | 1 | Finished operation failed |
| arr_rd_en | output | 1 | Array read enable for verify |
| arr_rd_addr | output | ADDR_W | Array read address |
| arr_rdata | input | DATA_W | Array read data |

## Verification
The assertions check on every cycle that request fields hold while back-pressured and that a request only appears while armed and busy. They also check that lock bits fall only under a chip-erase request, that reads stay silent outside host mode or under lock, and that the rejected flag never drops. Which command gets refused for which lock pattern, and the exact returned bytes, come from the bench scenarios. So do the loss of arming on leaving host mode, the timeout handling and the size-dependent block-2 refusal, which the bench compares against its own model across random command streams.

// File: rtl/fhc_pkg.sv
package fhc_pkg;
  typedef enum logic [1:0] {
    OP_CHIP = 2'b00,
    OP_BLK1 = 2'b01,
    OP_BLK2 = 2'b10,
    OP_PROG = 2'b11
  } arr_op_e;

  localparam logic [3:0] C_SIG   = 4'h0;
  localparam logic [3:0] C_CHIP  = 4'h1;
  localparam logic [3:0] C_BLK1  = 4'h2;
  localparam logic [3:0] C_BLK2  = 4'h4;
  localparam logic [3:0] C_PROG  = 4'hE;
  localparam logic [3:0] C_LB1   = 4'hF;
  localparam logic [3:0] C_LB2   = 4'h3;
  localparam logic [3:0] C_LB3   = 4'h5;
  localparam logic [3:0] C_VLOCK = 4'h9;
  localparam logic [3:0] C_VMAIN = 4'hC;

  function automatic logic [7:0] size_code(int kb);
    if (kb == 16) return 8'h04;
    if (kb == 32) return 8'h08;
    return 8'h10;
  endfunction
endpackage

// File: rtl/fhc_strobe_sync.sv
module fhc_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic fall
);
  // chain[0..STAGES-1] synchroniser, chain[STAGES] previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], strobe_n};
  end

  assign fall = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/fhc_cmd_gate.sv
module fhc_cmd_gate
  import fhc_pkg::*;
#(
  parameter bit HAS_BLK2 = 1'b1
) (
  input  logic [3:0] cmd,
  input  logic [2:0] lock,
  input  logic       armed,
  input  logic       busy,
  output logic       go_arr,
  output arr_op_e    op,
  output logic [2:0] lock_set,
  output logic       refuse
);
  logic protect;
  logic is_write;

  always_comb begin
    protect  = lock[1] | lock[2];
    go_arr   = 1'b0;
    op       = OP_PROG;
    lock_set = '0;
    refuse   = 1'b0;
    case (cmd)
      C_CHIP: begin op = OP_CHIP; go_arr = 1'b1; end
      C_BLK1: begin op = OP_BLK1; go_arr = !protect; refuse = protect; end
      C_BLK2: begin
        op     = OP_BLK2;
        go_arr = HAS_BLK2 && !protect;
        refuse = !(HAS_BLK2 && !protect);
      end
      C_PROG: begin op = OP_PROG; go_arr = !protect; refuse = protect; end
      C_LB1:  lock_set = 3'b001;
      C_LB2:  lock_set = 3'b010;
      C_LB3:  lock_set = 3'b100;
      default: ;
    endcase
    is_write = go_arr | refuse | (|lock_set);
    if (is_write && (!armed || busy)) begin
      go_arr   = 1'b0;
      lock_set = '0;
      refuse   = 1'b1;
    end
  end
endmodule

// File: rtl/fhc_read_mux.sv
module fhc_read_mux
  import fhc_pkg::*;
#(
  parameter int SIZE_KB  = 64,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int SIG_BASE = 'h30
) (
  input  logic              host,
  input  logic [3:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        lock,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              sig_hit,
  output logic              arr_rd_en
);
  localparam logic [7:0] SZ_CODE = size_code(SIZE_KB);
  localparam int         SIG_N   = 3;

  logic [ADDR_W-1:0] off;
  assign off = addr - ADDR_W'(SIG_BASE);

  always_comb begin
    dout      = '0;
    dout_en   = 1'b0;
    sig_hit   = 1'b0;
    arr_rd_en = 1'b0;
    if (host) begin
      case (cmd)
        C_SIG: if (off < ADDR_W'(SIG_N)) begin
          sig_hit = 1'b1;
          dout_en = 1'b1;
          case (off[1:0])
            2'd0:    dout = DATA_W'(8'hD5);
            2'd1:    dout = DATA_W'(SZ_CODE);
            default: dout = DATA_W'(8'hFF);
          endcase
        end
        C_VLOCK: begin
          dout_en = 1'b1;
          dout    = DATA_W'({4'b0000, lock, 1'b0});
        end
        C_VMAIN: if (lock == 3'b000) begin
          arr_rd_en = 1'b1;
          dout_en   = 1'b1;
          dout      = arr_rdata;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/flash_host_ctrl.sv
module flash_host_ctrl
  import fhc_pkg::*;
#(
  parameter int SIZE_KB     = 64,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_pin,
  input  logic              psen_n,
  input  logic              prog_n,
  input  logic [3:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              busy,
  output logic              timeout,
  output logic              rejected,
  output logic              arr_valid,
  input  logic              arr_ready,
  output logic [1:0]        arr_op,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  input  logic              arr_done,
  input  logic              arr_fail,
  output logic              arr_rd_en,
  output logic [ADDR_W-1:0] arr_rd_addr,
  input  logic [DATA_W-1:0] arr_rdata
);
  localparam bit HAS_BLK2 = (SIZE_KB == 64);

  logic       host;
  logic       armed;
  logic [2:0] lock_q;
  logic       fall;
  logic       sig_hit;
  logic       go_arr;
  arr_op_e    op;
  logic [2:0] lock_set;
  logic       refuse;

  assign host        = rst_pin & ~psen_n;
  assign arr_rd_addr = addr;

  fhc_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(prog_n), .fall(fall)
  );

  fhc_cmd_gate #(.HAS_BLK2(HAS_BLK2)) u_gate (
    .cmd(cmd), .lock(lock_q), .armed(armed), .busy(busy),
    .go_arr(go_arr), .op(op), .lock_set(lock_set), .refuse(refuse)
  );

  fhc_read_mux #(.SIZE_KB(SIZE_KB), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .host(host), .cmd(cmd), .addr(addr), .lock(lock_q), .arr_rdata(arr_rdata),
    .dout(dout), .dout_en(dout_en), .sig_hit(sig_hit), .arr_rd_en(arr_rd_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      lock_q    <= '0;
      arr_valid <= 1'b0;
      arr_op    <= '0;
      arr_addr  <= '0;
      arr_data  <= '0;
      busy      <= 1'b0;
      timeout   <= 1'b0;
      rejected  <= 1'b0;
    end else begin
      if (!host)        armed <= 1'b0;
      else if (sig_hit) armed <= 1'b1;

      if (arr_valid && arr_ready) arr_valid <= 1'b0;

      if (busy && !arr_valid && arr_done) begin
        busy    <= 1'b0;
        timeout <= arr_fail;
      end

      if (host && fall) begin
        if (go_arr) begin
          arr_valid <= 1'b1;
          arr_op    <= op;
          arr_addr  <= addr;
          arr_data  <= din;
          busy      <= 1'b1;
          timeout   <= 1'b0;
          if (op == OP_CHIP) lock_q <= '0;
        end else if (|lock_set) begin
          lock_q <= lock_q | lock_set;
        end
        if (refuse) rejected <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fhc_chk.sv
module fhc_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_pin,
  input logic              psen_n,
  input logic [3:0]        cmd,
  input logic              dout_en,
  input logic              busy,
  input logic              rejected,
  input logic              arr_valid,
  input logic              arr_ready,
  input logic [1:0]        arr_op,
  input logic [ADDR_W-1:0] arr_addr,
  input logic [DATA_W-1:0] arr_data,
  input logic              armed,
  input logic [2:0]        lock_q
);
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && !arr_ready) |=> (arr_valid && $stable(arr_op) && $stable(arr_addr) && $stable(arr_data)));

  // R5
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_valid |-> busy);

  // R3
  armed_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arr_valid) |-> $past(armed));

  // R10
  locked_verify_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'hC && lock_q != 3'b000) |-> !dout_en);

  // R9
  lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(lock_q) & ~lock_q)) |-> (arr_valid && arr_op == 2'b00));

  // R12
  sticky_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rejected) |-> rejected);

  // R1
  host_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_pin || psen_n) |-> !dout_en);
endmodule

bind flash_host_ctrl fhc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .psen_n(psen_n), .cmd(cmd),
  .dout_en(dout_en), .busy(busy), .rejected(rejected), .arr_valid(arr_valid),
  .arr_ready(arr_ready), .arr_op(arr_op), .arr_addr(arr_addr), .arr_data(arr_data),
  .armed(armed), .lock_q(lock_q)
);

// File: tb/sim_flash_host_ctrl.sv
module sim_flash_host_ctrl;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, rst_pin, psen_n, prog_n;
  logic [3:0]  cmd;
  logic [15:0] addr;
  logic [7:0]  din;
  logic        a_ready, a_done, a_fail;
  logic [7:0]  a_rdata;
  assign a_rdata = addr[7:0] ^ 8'h3C;

  logic [7:0]  d_out, b_out;
  logic        d_en, busy, tmo, rej, av, rd_en;
  logic [1:0]  aop;
  logic [15:0] aaddr, rd_addr;
  logic [7:0]  adata;
  logic        b_en, b_busy, b_tmo, b_rej, b_av, b_rd_en;
  logic [1:0]  b_op;
  logic [15:0] b_addr, b_rd_addr;
  logic [7:0]  b_data;

  flash_host_ctrl #(.SIZE_KB(64)) u0 (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .psen_n(psen_n), .prog_n(prog_n),
    .cmd(cmd), .addr(addr), .din(din), .dout(d_out), .dout_en(d_en), .busy(busy),
    .timeout(tmo), .rejected(rej), .arr_valid(av), .arr_ready(a_ready), .arr_op(aop),
    .arr_addr(aaddr), .arr_data(adata), .arr_done(a_done), .arr_fail(a_fail),
    .arr_rd_en(rd_en), .arr_rd_addr(rd_addr), .arr_rdata(a_rdata));

  flash_host_ctrl #(.SIZE_KB(32)) u1 (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .psen_n(psen_n), .prog_n(prog_n),
    .cmd(cmd), .addr(addr), .din(din), .dout(b_out), .dout_en(b_en), .busy(b_busy),
    .timeout(b_tmo), .rejected(b_rej), .arr_valid(b_av), .arr_ready(1'b1), .arr_op(b_op),
    .arr_addr(b_addr), .arr_data(b_data), .arr_done(1'b1), .arr_fail(1'b0),
    .arr_rd_en(b_rd_en), .arr_rd_addr(b_rd_addr), .arr_rdata(a_rdata));

  int total = 0;
  int bad   = 0;
  logic       m_host, m_armed, m_rej, m_busy, m_pend, m_tmo;
  logic [2:0] m_lock;
  logic [15:0] m_paddr;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic is_sig(logic [15:0] a);
    return a >= 16'h0030 && a <= 16'h0032;
  endfunction

  function automatic logic [8:0] exp_read(logic h, logic [3:0] c, logic [15:0] a,
                                         logic [2:0] lk, int kb);
    if (!h) return 9'h000;
    case (c)
      4'h0: begin
        if (!is_sig(a)) return 9'h000;
        if (a == 16'h0030) return {1'b1, 8'hD5};
        if (a == 16'h0031) return {1'b1, (kb == 16) ? 8'h04 : (kb == 32) ? 8'h08 : 8'h10};
        return {1'b1, 8'hFF};
      end
      4'h9: return {1'b1, 4'b0000, lk, 1'b0};
      4'hC: return (lk == 3'b000) ? {1'b1, a[7:0] ^ 8'h3C} : 9'h000;
      default: return 9'h000;
    endcase
  endfunction

  // 0 nothing, 1 array request, 2 lock set, 3 refused
  function automatic int exp_kind(logic [3:0] c, logic arm, logic [2:0] lk, logic bz, logic has2);
    logic prot;
    int k;
    prot = lk[1] | lk[2];
    case (c)
      4'h1: k = 1;
      4'h2: k = prot ? 3 : 1;
      4'h4: k = (!has2 || prot) ? 3 : 1;
      4'hE: k = prot ? 3 : 1;
      4'hF, 4'h3, 4'h5: k = 2;
      default: return 0;
    endcase
    if (!arm || bz) k = 3;
    return k;
  endfunction

  function automatic logic [1:0] exp_op(logic [3:0] c);
    case (c)
      4'h1: return 2'b00;
      4'h2: return 2'b01;
      4'h4: return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  function automatic logic [2:0] exp_lset(logic [3:0] c);
    case (c)
      4'hF: return 3'b001;
      4'h3: return 3'b010;
      4'h5: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pins(logic [3:0] c, logic [15:0] a, logic [7:0] d);
    cmd = c; addr = a; din = d;
    if (m_host && c == 4'h0 && is_sig(a)) m_armed = 1'b1;
  endtask

  task automatic power_cycle();
    set_pins(4'hC, 16'h0000, 8'h00);
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    m_armed = 0; m_lock = 0; m_rej = 0; m_busy = 0; m_pend = 0; m_tmo = 0;
    tick(1);
  endtask

  task automatic set_host(logic h);
    set_pins(4'hC, 16'h0000, 8'h00);
    rst_pin = h; psen_n = !h; m_host = h;
    if (!h) m_armed = 1'b0;
    tick(2);
  endtask

  task automatic read_chk(logic [3:0] c, logic [15:0] a, string req);
    set_pins(c, a, 8'h00);
    tick(1);
    check(req, {23'd0, d_en, d_out}, {23'd0, exp_read(m_host, c, a, m_lock, 64)});
  endtask

  task automatic serve(logic f, string req);
    a_ready = 1'b1;
    tick(1);
    a_ready = 1'b0;
    m_pend = 1'b0;
    check(req, {30'd0, av, busy}, {30'd0, 1'b0, 1'b1});
    tick(2);
    a_done = 1'b1; a_fail = f;
    tick(1);
    a_done = 1'b0; a_fail = 1'b0;
    tick(1);
    m_busy = 1'b0; m_tmo = f;
    check(req, {30'd0, busy, tmo}, {30'd0, 1'b0, f});
  endtask

  task automatic strobe(logic [3:0] c, logic [15:0] a, logic [7:0] d,
                        logic f, logic do_serve, string req);
    int k;
    set_pins(c, a, d);
    k = m_host ? exp_kind(c, m_armed, m_lock, m_busy, 1'b1) : 0;
    tick(1);
    prog_n = 1'b0;
    tick(5);
    prog_n = 1'b1;
    tick(2);
    check(req, {31'd0, av}, {31'd0, (k == 1) || m_pend});
    if (k == 1) begin
      check(req, {6'd0, aop, aaddr, adata}, {6'd0, exp_op(c), a, d});
      check(req, {30'd0, busy, tmo}, {30'd0, 1'b1, 1'b0});
      if (c == 4'h1) m_lock = 3'b000;
      m_busy = 1'b1; m_pend = 1'b1; m_tmo = 1'b0; m_paddr = a;
    end else begin
      check(req, {30'd0, busy, tmo}, {30'd0, m_busy, m_tmo});
      if (m_pend) check(req, {16'd0, aaddr}, {16'd0, m_paddr});
    end
    if (k == 2) m_lock = m_lock | exp_lset(c);
    if (k == 3) m_rej = 1'b1;
    check(req, {31'd0, rej}, {31'd0, m_rej});
    if (k == 1 && do_serve) serve(f, req);
  endtask

  function automatic logic [3:0] pick_cmd();
    case ($urandom_range(0, 9))
      0: return 4'h0; 1: return 4'h1; 2: return 4'h2; 3: return 4'h4; 4: return 4'hE;
      5: return 4'hF; 6: return 4'h3; 7: return 4'h5; 8: return 4'h9;
      default: return 4'hC;
    endcase
  endfunction

  function automatic logic [15:0] pick_addr();
    if ($urandom_range(0, 1) == 0) return 16'h0030 + 16'($urandom_range(0, 3));
    return 16'($urandom);
  endfunction

  logic finished = 1'b0;

  initial begin
    #(150000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; rst_pin = 0; psen_n = 1; prog_n = 1;
    cmd = 4'hC; addr = 0; din = 0;
    a_ready = 0; a_done = 0; a_fail = 0;
    m_host = 0; m_armed = 0; m_lock = 0; m_rej = 0; m_busy = 0; m_pend = 0; m_tmo = 0; m_paddr = 0;
    tick(3);
    rst_n = 1;
    tick(1);

    // R12 reset state
    check("R12", {27'd0, d_en, busy, tmo, rej, av}, 32'd0);
    // R1 outside host mode
    read_chk(4'h0, 16'h0030, "R1");
    strobe(4'h1, 16'h0000, 8'h00, 1'b0, 1'b1, "R1");

    // R3 unarmed write refused
    set_host(1'b1);
    strobe(4'hE, 16'h1234, 8'hA5, 1'b0, 1'b1, "R3");

    // R2 signature bytes
    power_cycle();
    set_host(1'b1);
    read_chk(4'h0, 16'h0030, "R2");
    read_chk(4'h0, 16'h0031, "R2");
    check("R2", {23'd0, b_en, b_out}, {23'd0, 1'b1, 8'h08});
    read_chk(4'h0, 16'h0032, "R2");
    read_chk(4'h0, 16'h0033, "R2");

    // R4 program byte, R6 failure reported
    strobe(4'hE, 16'h1234, 8'hA5, 1'b1, 1'b1, "R4");
    // R7 lock bit 1, R6 undisturbed
    strobe(4'hF, 16'h0000, 8'h00, 1'b0, 1'b1, "R7");
    read_chk(4'h9, 16'h0000, "R7");
    // R9 chip erase clears lock, R6 timeout cleared
    strobe(4'h1, 16'h0000, 8'h00, 1'b0, 1'b1, "R9");
    read_chk(4'h9, 16'h0000, "R9");
    // R8 lock bit 2 protection
    strobe(4'h3, 16'h0000, 8'h00, 1'b0, 1'b1, "R7");
    read_chk(4'h9, 16'h0000, "R7");
    strobe(4'h2, 16'h0000, 8'h00, 1'b0, 1'b1, "R8");
    strobe(4'hE, 16'h0040, 8'h11, 1'b0, 1'b1, "R8");
    read_chk(4'hC, 16'h0055, "R10");
    strobe(4'h5, 16'h0000, 8'h00, 1'b0, 1'b1, "R7");
    read_chk(4'h9, 16'h0000, "R7");
    strobe(4'h1, 16'h0000, 8'h00, 1'b0, 1'b1, "R9");
    read_chk(4'h9, 16'h0000, "R9");
    // R10 verify with no lock
    read_chk(4'hC, 16'h01A7, "R10");
    check("R10", {31'd0, rd_en}, 32'd1);
    // R5 write refused while busy
    strobe(4'hE, 16'h0100, 8'h22, 1'b0, 1'b0, "R5");
    strobe(4'h1, 16'h0000, 8'h00, 1'b0, 1'b1, "R5");
    serve(1'b0, "R5");
    // R3 arming lost on leaving host mode
    set_host(1'b0);
    set_host(1'b1);
    strobe(4'hE, 16'h0200, 8'h33, 1'b0, 1'b1, "R3");

    // R11 block 2 only in the 64K variant
    power_cycle();
    set_host(1'b1);
    read_chk(4'h0, 16'h0032, "R2");
    strobe(4'h4, 16'hF000, 8'h00, 1'b0, 1'b1, "R11");
    check("R11", {30'd0, b_rej, rej}, {30'd0, 1'b1, 1'b0});

    // random command streams
    power_cycle();
    set_host(1'b1);
    for (int i = 0; i < 400; i++) begin
      int r;
      logic [3:0] c;
      r = $urandom_range(0, 99);
      c = pick_cmd();
      if (r < 35) begin
        read_chk(c, pick_addr(), (c == 4'h9) ? "R7" : (c == 4'hC) ? "R10" : "R2");
      end else if (r < 90) begin
        strobe(c, pick_addr(), 8'($urandom), ($urandom_range(0, 3) == 0), 1'b1,
               (m_lock[1] | m_lock[2]) ? "R8" : m_armed ? "R4" : "R3");
      end else if (r < 96) begin
        set_host(1'b0);
        set_host(1'b1);
      end else begin
        power_cycle();
        set_host(1'b1);
      end
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule